// File: doc/BRIEF.md
# Stack and Subroutine Call Unit

This unit holds the data stack of a small 8-bit processor core in its own byte-wide SRAM model and carries out the four stack-related operations: push of one register byte, pop of one byte, relative subroutine call and return. It owns the stack pointer, works out the call target from the current word program counter and a signed 12-bit word offset, and reports the number of extra execution cycles each operation costs, so the surrounding core can account for them.

The core raises exactly one bit of a one-hot request for one clock while the unit is idle. The unit accepts it, performs one SRAM byte access per clock, and pulses a done strobe for one cycle after the last byte. The new program counter, the popped byte and the extra-cycle count are then valid and stay valid until the next operation completes. A static mode input chooses between a 2-byte and a 3-byte return address; a static mask input sets the usable SRAM size, so the pointer wraps inside it.

Top module: `stkcall_unit`

## Requirements
- R1: While and right after reset, `sp` equals `size_mask`, `op_done` is 0 and `busy` is 0.
- R2: A push (`op_req` = 4'b0001) stores `wr_byte` at the address held in `sp`, and `sp` then becomes (`sp` - 1) AND `size_mask`.
- R3: A pop (`op_req` = 4'b0010) first sets `sp` to (`sp` + 1) AND `size_mask`, then returns the byte at that new address on `pop_byte`.
- R4: Every pointer update and every byte address is ANDed with `size_mask`, so a push at address 0 leaves `sp` at the mask value and a pop at the mask value leaves `sp` at 0.
- R5: A call (`op_req` = 4'b0100) writes `cur_pc` + 1 as 2 bytes when `wide_pc` is 0 or 3 bytes when it is 1, least significant byte at `sp` and each further byte at the next higher masked address, then lowers `sp` by 2 or 3 (masked).
- R6: After a call, `next_pc` equals `cur_pc` + 1 + the sign-extended 12-bit `call_ofs`, modulo 2^PC_W.
- R7: A return (`op_req` = 4'b1000) raises `sp` by 2 or 3 (masked), reads that many bytes from the new `sp` upward, least significant first, and sets `next_pc` to the assembled value, zero-extended.
- R8: With `op_done`, `extra_cycles` is 1 for push and pop, 2 for call and 3 for return, each of call and return one more when `wide_pc` is 1.
- R9: One byte moves per clock: `op_done` is a one-cycle pulse exactly N cycles after the accepting edge for an N-byte operation, with `busy` high in between.
- R10: A request raised while `busy` is high is ignored: it changes neither `sp`, the stack contents nor the outputs, and produces no extra `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req | input | 4 | One-hot request: bit0 push, bit1 pop, bit2 call, bit3 return |
| wr_byte | input | 8 | Register byte to push |
| call_ofs | input | OFS_W (12) | Signed word offset of a call |
| cur_pc | input | PC_W (22) | Word address of the calling instruction |
| wide_pc | input | 1 | 1 selects 3-byte return addresses; static |
| size_mask | input | ADDR_W (8) | SRAM size mask; static, applied under reset |
| next_pc | output | PC_W (22) | Call target or returned address |
| pop_byte | output | 8 | Byte returned by the last pop |
| op_done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Operation in progress; requests ignored |
| extra_cycles | output | 3 | Extra execution cycles of the completed operation |
| sp | output | ADDR_W (8) | Current stack pointer |

## Verification
The checker takes for granted that `op_req` has at most one bit set, and that `wide_pc` and `size_mask` only change while reset is held; its expected lengths and costs are latched from these at the accepting edge. The bench respects this by changing the mode and mask only inside its reset task and by driving only the four one-hot codes, with the single deliberate exception of a request raised during a busy period to show that it is ignored.

// File: rtl/stkcall_pkg.sv
package stkcall_pkg;

    localparam int REQ_W = 4;
    localparam int RA_W  = 24;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } stk_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic [1:0] len;
        logic [2:0] cost;
    } op_info_t;

    function automatic stk_op_e decode_req(input logic [REQ_W-1:0] req);
        if (req[3])      return OP_RET;
        else if (req[2]) return OP_CALL;
        else if (req[1]) return OP_POP;
        else             return OP_PUSH;
    endfunction

    function automatic op_info_t op_info(input stk_op_e op, input logic wide);
        op_info_t r;
        case (op)
            OP_CALL: begin r.len = 2'(2 + wide); r.cost = 3'(2 + wide); end
            OP_RET:  begin r.len = 2'(2 + wide); r.cost = 3'(3 + wide); end
            default: begin r.len = 2'd1;         r.cost = 3'd1;         end
        endcase
        return r;
    endfunction

    function automatic logic writes_mem(input stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction

endpackage

// File: rtl/stkcall_ram.sv
module stkcall_ram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/stkcall_ptr.sv
module stkcall_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mask,
    input  logic              start,
    input  logic              grow_down,
    input  logic [1:0]        len,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W-1:0] sp_q, base_q, len_ext, sp_d;

    assign len_ext = ADDR_W'(len);
    assign sp_d    = grow_down ? ((sp_q - len_ext) & mask)
                               : ((sp_q + len_ext) & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= mask;
            base_q <= '0;
        end else if (start) begin
            sp_q   <= sp_d;
            base_q <= grow_down ? sp_q : sp_d;
        end
    end

    assign sp   = sp_q;
    assign base = base_q;

endmodule

// File: rtl/stkcall_seq.sv
module stkcall_seq
    import stkcall_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_W-1:0] req,
    input  logic [7:0]       wr_byte,
    input  logic [OFS_W-1:0] call_ofs,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             wide,
    input  logic [7:0]       rd_byte,
    output logic             start,
    output logic             grow_down,
    output logic [1:0]       len,
    output logic [1:0]       idx,
    output logic             ram_we,
    output logic [7:0]       ram_wdata,
    output logic             busy,
    output logic             done,
    output logic [PC_W-1:0]  next_pc,
    output logic [7:0]       pop_byte,
    output logic [2:0]       extra
);
    seq_st_e          state;
    stk_op_e          op_q, op_d;
    op_info_t         info_d;
    logic [1:0]       len_q, idx_q;
    logic [2:0]       cost_q;
    logic [RA_W-1:0]  payload_q, acc_q, acc_next;
    logic [PC_W-1:0]  target_q, ret_addr, target_d;
    logic             accept, last;

    assign accept   = (state == ST_IDLE) && (|req);
    assign op_d     = decode_req(req);
    assign info_d   = op_info(op_d, wide);
    assign ret_addr = cur_pc + PC_W'(1);
    assign target_d = ret_addr + {{(PC_W-OFS_W){call_ofs[OFS_W-1]}}, call_ofs};
    assign last     = (idx_q == (len_q - 2'd1));

    always_comb begin
        acc_next = acc_q;
        acc_next[{idx_q, 3'b000} +: 8] = rd_byte;
    end

    assign start     = accept;
    assign grow_down = writes_mem(op_d);
    assign len       = info_d.len;
    assign idx       = idx_q;
    assign busy      = (state == ST_XFER);
    assign ram_we    = busy && writes_mem(op_q);
    assign ram_wdata = payload_q[{idx_q, 3'b000} +: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_PUSH;
            len_q     <= 2'd1;
            cost_q    <= 3'd0;
            idx_q     <= 2'd0;
            payload_q <= '0;
            acc_q     <= '0;
            target_q  <= '0;
            done      <= 1'b0;
            next_pc   <= '0;
            pop_byte  <= '0;
            extra     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= op_d;
                        len_q     <= info_d.len;
                        cost_q    <= info_d.cost;
                        idx_q     <= 2'd0;
                        acc_q     <= '0;
                        payload_q <= (op_d == OP_CALL) ? RA_W'(ret_addr)
                                                       : RA_W'(wr_byte);
                        target_q  <= target_d;
                        state     <= ST_XFER;
                    end
                end
                default: begin
                    acc_q <= acc_next;
                    if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        extra <= cost_q;
                        case (op_q)
                            OP_POP:  pop_byte <= rd_byte;
                            OP_RET:  next_pc  <= PC_W'(acc_next);
                            OP_CALL: next_pc  <= target_q;
                            default: ;
                        endcase
                    end else begin
                        idx_q <= idx_q + 2'd1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/stkcall_unit.sv
module stkcall_unit
    import stkcall_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PC_W   = 22,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_req,
    input  logic [7:0]        wr_byte,
    input  logic [OFS_W-1:0]  call_ofs,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              wide_pc,
    input  logic [ADDR_W-1:0] size_mask,
    output logic [PC_W-1:0]   next_pc,
    output logic [7:0]        pop_byte,
    output logic              op_done,
    output logic              busy,
    output logic [2:0]        extra_cycles,
    output logic [ADDR_W-1:0] sp
);
    logic              start, grow_down, ram_we;
    logic [1:0]        len, idx;
    logic [7:0]        ram_wdata, ram_rdata;
    logic [ADDR_W-1:0] base, ram_addr;

    stkcall_seq #(.PC_W(PC_W), .OFS_W(OFS_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (op_req),
        .wr_byte   (wr_byte),
        .call_ofs  (call_ofs),
        .cur_pc    (cur_pc),
        .wide      (wide_pc),
        .rd_byte   (ram_rdata),
        .start     (start),
        .grow_down (grow_down),
        .len       (len),
        .idx       (idx),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .busy      (busy),
        .done      (op_done),
        .next_pc   (next_pc),
        .pop_byte  (pop_byte),
        .extra     (extra_cycles)
    );

    stkcall_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .mask      (size_mask),
        .start     (start),
        .grow_down (grow_down),
        .len       (len),
        .sp        (sp),
        .base      (base)
    );

    assign ram_addr = (base + ADDR_W'(idx)) & size_mask;

    stkcall_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/stkcall_chk.sv
module stkcall_chk #(
    parameter int ADDR_W = 8,
    parameter int PC_W   = 22,
    parameter int OFS_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_req,
    input logic [OFS_W-1:0]  call_ofs,
    input logic [PC_W-1:0]   cur_pc,
    input logic              wide_pc,
    input logic [ADDR_W-1:0] size_mask,
    input logic [PC_W-1:0]   next_pc,
    input logic              op_done,
    input logic              busy,
    input logic [2:0]        extra_cycles,
    input logic [ADDR_W-1:0] sp
);
    logic            take;
    logic [2:0]      cnt, exp_len, exp_cost;
    logic            exp_call;
    logic [PC_W-1:0] exp_tgt;

    assign take = !busy && (|op_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            exp_len  <= '0;
            exp_cost <= '0;
            exp_call <= 1'b0;
            exp_tgt  <= '0;
        end else if (take) begin
            cnt      <= '0;
            exp_len  <= (op_req[0] || op_req[1]) ? 3'd1 : (wide_pc ? 3'd3 : 3'd2);
            exp_cost <= (op_req[0] || op_req[1]) ? 3'd1 :
                        op_req[2] ? (wide_pc ? 3'd3 : 3'd2) : (wide_pc ? 3'd4 : 3'd3);
            exp_call <= op_req[2];
            exp_tgt  <= cur_pc + PC_W'(1) + {{(PC_W-OFS_W){call_ofs[OFS_W-1]}}, call_ofs};
        end else if (busy) begin
            cnt <= cnt + 3'd1;
        end
    end

    a_r2_push_lowers_sp: assert property (@(posedge clk) disable iff (rst)
        (take && op_req == 4'b0001) |=> sp == (($past(sp) - ADDR_W'(1)) & size_mask));

    a_r3_pop_raises_sp: assert property (@(posedge clk) disable iff (rst)
        (take && op_req == 4'b0010) |=> sp == (($past(sp) + ADDR_W'(1)) & size_mask));

    a_r4_sp_within_mask: assert property (@(posedge clk) disable iff (rst)
        (sp & ~size_mask) == '0);

    a_r5_call_lowers_sp: assert property (@(posedge clk) disable iff (rst)
        (take && op_req == 4'b0100) |=>
        sp == (($past(sp) - (wide_pc ? ADDR_W'(3) : ADDR_W'(2))) & size_mask));

    a_r6_call_target: assert property (@(posedge clk) disable iff (rst)
        (op_done && exp_call) |-> next_pc == exp_tgt);

    a_r8_extra_cost: assert property (@(posedge clk) disable iff (rst)
        op_done |-> extra_cycles == exp_cost);

    a_r9_byte_per_clock: assert property (@(posedge clk) disable iff (rst)
        op_done |-> cnt == exp_len);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);

    a_r10_sp_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(sp));

endmodule

bind stkcall_unit stkcall_chk #(.ADDR_W(ADDR_W), .PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_req       (op_req),
    .call_ofs     (call_ofs),
    .cur_pc       (cur_pc),
    .wide_pc      (wide_pc),
    .size_mask    (size_mask),
    .next_pc      (next_pc),
    .op_done      (op_done),
    .busy         (busy),
    .extra_cycles (extra_cycles),
    .sp           (sp)
);

// File: tb/stkcall_unit_tb.sv
module stkcall_unit_tb;
    localparam int AW = 4;
    localparam int PW = 22;
    localparam int OW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    op_req;
    logic [7:0]    wr_byte;
    logic [OW-1:0] call_ofs;
    logic [PW-1:0] cur_pc;
    logic          wide_pc;
    logic [AW-1:0] size_mask;
    logic [PW-1:0] next_pc;
    logic [7:0]    pop_byte;
    logic          op_done, busy;
    logic [2:0]    extra_cycles;
    logic [AW-1:0] sp;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]    mem_m [1<<AW];
    logic [AW-1:0] sp_m;

    always #5 clk = ~clk;

    stkcall_unit #(.ADDR_W(AW), .PC_W(PW), .OFS_W(OW)) u_dut (
        .clk(clk), .rst(rst), .op_req(op_req), .wr_byte(wr_byte),
        .call_ofs(call_ofs), .cur_pc(cur_pc), .wide_pc(wide_pc),
        .size_mask(size_mask), .next_pc(next_pc), .pop_byte(pop_byte),
        .op_done(op_done), .busy(busy), .extra_cycles(extra_cycles), .sp(sp)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        report();
        $finish;
    end

    task automatic do_reset(input logic [AW-1:0] m, input logic w);
        @(negedge clk);
        rst = 1'b1; op_req = '0; wr_byte = '0; call_ofs = '0; cur_pc = '0;
        size_mask = m; wide_pc = w;
        repeat (3) @(negedge clk);
        chk(sp == m, "R1 sp in reset", 32'(sp), 32'(m));
        rst = 1'b0;
        @(negedge clk);
        sp_m = m;
        chk(sp == m, "R1 sp after reset", 32'(sp), 32'(m));
        chk(!op_done && !busy, "R1 done/busy idle", {op_done, busy}, 0);
    endtask

    // Issues one request; optionally raises a push request while busy.
    task automatic run_op(input logic [3:0] rq, input logic [7:0] d, input logic [OW-1:0] ofs,
                          input logic [PW-1:0] pc, input bit inject, output int lat);
        @(negedge clk);
        op_req = rq; wr_byte = d; call_ofs = ofs; cur_pc = pc;
        @(negedge clk);
        op_req = inject ? 4'b0001 : 4'b0000;
        wr_byte = 8'h5A;
        lat = 0;
        while (!op_done && lat < 20) begin
            @(negedge clk);
            op_req = '0;
            lat++;
        end
    endtask

    task automatic finish_op(input int lat, input int n, input int cost, input string tag);
        chk(lat == n, {tag, " R9 latency"}, 32'(lat), 32'(n));
        chk(extra_cycles == 3'(cost), {tag, " R8 extra cycles"}, 32'(extra_cycles), 32'(cost));
        chk(sp == sp_m, {tag, " R4 sp"}, 32'(sp), 32'(sp_m));
        @(negedge clk);
        chk(!op_done && !busy, {tag, " R9 single pulse"}, {op_done, busy}, 0);
    endtask

    task automatic do_push(input logic [7:0] d);
        int lat;
        run_op(4'b0001, d, '0, '0, 1'b0, lat);
        mem_m[sp_m] = d;
        sp_m = (sp_m - 1'b1) & size_mask;
        finish_op(lat, 1, 1, "R2 push");
    endtask

    task automatic do_pop();
        int lat;
        logic [7:0] e;
        run_op(4'b0010, 8'h00, '0, '0, 1'b0, lat);
        sp_m = (sp_m + 1'b1) & size_mask;
        e = mem_m[sp_m];
        chk(pop_byte == e, "R3 pop data", 32'(pop_byte), 32'(e));
        finish_op(lat, 1, 1, "R3 pop");
    endtask

    task automatic do_call(input logic [PW-1:0] pc, input logic [OW-1:0] ofs, input bit inject);
        int lat, n;
        logic [PW-1:0] ra, tgt;
        logic [23:0] ra24;
        run_op(4'b0100, 8'h00, ofs, pc, inject, lat);
        n = wide_pc ? 3 : 2;
        ra = pc + 1'b1;
        ra24 = 24'(ra);
        tgt = ra + {{(PW-OW){ofs[OW-1]}}, ofs};
        for (int i = 0; i < n; i++) mem_m[(sp_m + AW'(i)) & size_mask] = ra24[8*i +: 8];
        sp_m = (sp_m - AW'(n)) & size_mask;
        chk(next_pc == tgt, "R6 call target", 32'(next_pc), 32'(tgt));
        finish_op(lat, n, wide_pc ? 3 : 2, inject ? "R10 ignored req R5 call" : "R5 call");
    endtask

    task automatic do_ret();
        int lat, n;
        logic [23:0] v;
        run_op(4'b1000, 8'h00, '0, '0, 1'b0, lat);
        n = wide_pc ? 3 : 2;
        sp_m = (sp_m + AW'(n)) & size_mask;
        v = '0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = mem_m[(sp_m + AW'(i)) & size_mask];
        chk(next_pc == PW'(v), "R7 return address", 32'(next_pc), 32'(PW'(v)));
        finish_op(lat, n, wide_pc ? 4 : 3, "R7 ret");
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [PW-1:0] pcs [4];
        logic [OW-1:0] ofss [6];
        pcs[0] = 22'h000000; pcs[1] = 22'h012345; pcs[2] = 22'h3FFFFF; pcs[3] = 22'h00FFFF;
        ofss[0] = 12'h800; ofss[1] = 12'hFFF; ofss[2] = 12'h000;
        ofss[3] = 12'h001; ofss[4] = 12'h7FF; ofss[5] = 12'h123;

        do_reset(4'hF, 1'b0);
        // Fill the whole ring, wrapping at address 0 (R2, R4).
        for (int i = 0; i < 18; i++) do_push(8'(8'hA0 + i * 7));
        for (int i = 0; i < 18; i++) do_pop();
        // Narrow call/return sweep (R5, R6, R7, R8).
        foreach (pcs[p]) foreach (ofss[o]) begin
            do_call(pcs[p], ofss[o], 1'b0);
            do_ret();
        end
        // Byte order: pushes followed by a return (R7).
        do_push(8'h12); do_push(8'h34); do_push(8'h56);
        do_ret();
        do_pop();

        do_reset(4'h7, 1'b1);
        for (int i = 0; i < 10; i++) do_push(8'(8'h31 + i));
        for (int i = 0; i < 10; i++) do_pop();
        foreach (pcs[p]) foreach (ofss[o]) begin
            do_call(pcs[p], ofss[o], 1'b0);
            do_ret();
        end
        // Request raised while busy must be ignored (R10).
        do_call(22'h2ABCDE, 12'h010, 1'b1);
        do_ret();

        // Mixed sequence, wide mode, small mask.
        lfsr = 16'hACE1;
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'd0: do_push(lfsr[15:8]);
                2'd1: do_pop();
                2'd2: do_call(PW'({lfsr, lfsr[5:0]}), lfsr[11:0], 1'b0);
                default: do_ret();
            endcase
        end

        do_reset(4'hF, 1'b0);
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'd0: do_push(lfsr[7:0]);
                2'd1: do_pop();
                2'd2: do_call(PW'({lfsr[9:0], lfsr}), lfsr[15:4], 1'b0);
                default: do_ret();
            endcase
        end

        report();
        $finish;
    end

endmodule